// File: doc/BRIEF.md
# Transactional Cache Line Tracker

This block follows one hardware memory transaction across a small direct-mapped array of data cache lines. Each line holds a valid bit, an address tag, a read-membership bit and a write-membership bit. The core sends begin, end and abort commands and reports its loads and stores by line index and tag. The coherence side reports remote snoops, evictions and downgrades by line index. From these inputs the block decides, every cycle, whether the transaction carries on, commits or aborts.

Nesting is flat. Each begin command raises a depth counter and each end command lowers it. The transaction is visible as committed only when the outermost end arrives. Any abort condition at any depth ends the whole nest. On abort, speculatively written lines are invalidated so that their data is dropped. The core then sees a one-cycle abort pulse with a cause code. A downgrade that hits a written line also raises a same-cycle flag, which tells the coherence side that the forward request failed and that memory must supply the data.

Top module: `txn_line_tracker`

## Requirements
- R1: After reset the depth is 0, txn_active is low, commit_pulse and abort_pulse are low, abort_cause is 0, and line_valid, rd_set and wr_set are all zero.
- R2: A load or store fills its line: it sets line_valid and records the tag. While txn_active is high, a load also sets the line's rd_set bit and a store also sets its wr_set bit. Outside a transaction, no membership bit is set.
- R3: While active, a remote snoop, read or write, whose index hits a line with its rd_set or wr_set bit set causes an abort with cause 2 (conflict).
- R4: A begin command raises the depth by 1. An end command lowers it by 1. An end command that takes the depth from a value above 1 produces no commit.
- R5: An end command at depth 1 produces commit_pulse high for exactly one cycle, in the cycle after the command. In that cycle the depth is 0 and rd_set and wr_set are zero, while line_valid is kept.
- R6: Every abort produces abort_pulse for one cycle in the cycle after the cause. In that cycle the depth is 0, rd_set and wr_set are zero, and every line that was in the write set is no longer valid. Lines that were only read stay valid.
- R7: An abort command while active aborts with cause 1 (explicit). An abort command while inactive has no effect.
- R8: While active, evicting a line whose rd_set or wr_set bit is set aborts with cause 3 (eviction). Any eviction clears the line's valid bit.
- R9: While active, a downgrade of a line in the write set drives fwd_fail high in the same cycle and aborts with cause 4 (downgrade). A downgrade of a line that is only in the read set has no effect.
- R10: While active, a load or store to a tracked line with a different tag aborts with cause 5 (capacity). A begin command at the largest depth also aborts with cause 5.
- R11: An abort condition wins over a final end command in the same cycle. When several causes coincide, the reported cause is the first of explicit, conflict, eviction, downgrade, capacity.
- R12: While inactive, end commands, snoops and downgrades do not change the depth, the line state or the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Open a (nested) transaction |
| cmd_end | input | 1 | Close one nesting level |
| cmd_abort | input | 1 | Explicit abort request |
| ld_valid | input | 1 | Local load this cycle |
| st_valid | input | 1 | Local store this cycle |
| acc_idx | input | IDX_W | Line index of the local access |
| acc_tag | input | TAG_W | Tag of the local access |
| snp_rd | input | 1 | Remote read snoop |
| snp_wr | input | 1 | Remote write snoop |
| snp_idx | input | IDX_W | Line index of the snoop |
| evict_valid | input | 1 | Line eviction event |
| evict_idx | input | IDX_W | Line index being evicted |
| dgrade_valid | input | 1 | Coherence downgrade event |
| dgrade_idx | input | IDX_W | Line index being downgraded |
| txn_active | output | 1 | Depth is non-zero |
| txn_depth | output | DEPTH_W | Current nesting depth |
| commit_pulse | output | 1 | One-cycle commit indication |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 3 | 1 explicit, 2 conflict, 3 eviction, 4 downgrade, 5 capacity |
| fwd_fail | output | 1 | Downgrade of a written line: memory must supply the data |
| line_valid | output | 2**IDX_W | Per-line valid bits |
| rd_set | output | 2**IDX_W | Per-line read membership |
| wr_set | output | 2**IDX_W | Per-line write membership |

## Verification
The bench uses the default parameters: 8 lines, 4-bit tags and a 3-bit depth counter. With 8 lines, read-only lines, written lines and untouched lines can sit side by side, so after an abort the bench can tell invalidated lines from kept ones. A depth limit of 7 lets a short run reach the nesting overflow, and 4-bit tags leave room to force a capacity conflict on one slot.

// File: rtl/txn_line_tracker.sv
module txn_line_tracker #(
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 4,
  parameter int DEPTH_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_begin,
  input  logic                    cmd_end,
  input  logic                    cmd_abort,
  input  logic                    ld_valid,
  input  logic                    st_valid,
  input  logic [IDX_W-1:0]        acc_idx,
  input  logic [TAG_W-1:0]        acc_tag,
  input  logic                    snp_rd,
  input  logic                    snp_wr,
  input  logic [IDX_W-1:0]        snp_idx,
  input  logic                    evict_valid,
  input  logic [IDX_W-1:0]        evict_idx,
  input  logic                    dgrade_valid,
  input  logic [IDX_W-1:0]        dgrade_idx,
  output logic                    txn_active,
  output logic [DEPTH_W-1:0]      txn_depth,
  output logic                    commit_pulse,
  output logic                    abort_pulse,
  output logic [2:0]              abort_cause,
  output logic                    fwd_fail,
  output logic [(1<<IDX_W)-1:0]   line_valid,
  output logic [(1<<IDX_W)-1:0]   rd_set,
  output logic [(1<<IDX_W)-1:0]   wr_set
);
  localparam int NL = 1 << IDX_W;
  localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};
  localparam logic [2:0] C_NONE = 3'd0, C_EXPL = 3'd1, C_CONF = 3'd2,
                         C_EVIC = 3'd3, C_DGRD = 3'd4, C_CAP  = 3'd5;

  logic [NL-1:0]      valid_q, rd_q, wr_q;
  logic [TAG_W-1:0]   tag_q [NL];
  logic [DEPTH_W-1:0] depth_q;
  logic               commit_q, abort_q;
  logic [2:0]         cause_q;

  logic [NL-1:0]      trk, valid_n, rd_n, wr_n;
  logic [TAG_W-1:0]   tag_n [NL];
  logic [DEPTH_W-1:0] depth_n;
  logic               active, acc, snp_hit, ev_hit, dg_hit, acc_cap, beg_cap;
  logic               abort_now, commit_now;
  logic [2:0]         cause_n;

  assign active  = depth_q != '0;
  assign trk     = rd_q | wr_q;
  assign acc     = ld_valid | st_valid;
  assign snp_hit = active & (snp_rd | snp_wr) & trk[snp_idx];
  assign ev_hit  = active & evict_valid & trk[evict_idx];
  assign dg_hit  = active & dgrade_valid & wr_q[dgrade_idx];
  assign acc_cap = active & acc & trk[acc_idx] & (tag_q[acc_idx] != acc_tag);
  assign beg_cap = cmd_begin & (depth_q == DMAX);

  always_comb begin
    if (active & cmd_abort)  cause_n = C_EXPL;
    else if (snp_hit)        cause_n = C_CONF;
    else if (ev_hit)         cause_n = C_EVIC;
    else if (dg_hit)         cause_n = C_DGRD;
    else if (acc_cap | beg_cap) cause_n = C_CAP;
    else                     cause_n = C_NONE;
  end

  assign abort_now  = cause_n != C_NONE;
  assign commit_now = !abort_now & cmd_end & !cmd_begin & (depth_q == 1);

  always_comb begin
    if (abort_now)                      depth_n = '0;
    else if (cmd_begin & !cmd_end)      depth_n = depth_q + 1'b1;
    else if (cmd_end & !cmd_begin & active) depth_n = depth_q - 1'b1;
    else                                depth_n = depth_q;
  end

  always_comb begin
    valid_n = valid_q;
    rd_n    = rd_q;
    wr_n    = wr_q;
    for (int i = 0; i < NL; i++) tag_n[i] = tag_q[i];
    if (acc & !acc_cap) begin
      valid_n[acc_idx] = 1'b1;
      tag_n[acc_idx]   = acc_tag;
      if (active) begin
        if (ld_valid) rd_n[acc_idx] = 1'b1;
        if (st_valid) wr_n[acc_idx] = 1'b1;
      end
    end
    if (evict_valid) valid_n[evict_idx] = 1'b0;
    if (abort_now) begin
      valid_n = valid_n & ~wr_n;
      rd_n    = '0;
      wr_n    = '0;
    end else if (commit_now) begin
      rd_n = '0;
      wr_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      depth_q  <= '0;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      cause_q  <= C_NONE;
      for (int i = 0; i < NL; i++) tag_q[i] <= '0;
    end else begin
      valid_q  <= valid_n;
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      depth_q  <= depth_n;
      commit_q <= commit_now;
      abort_q  <= abort_now;
      cause_q  <= cause_n;
      for (int i = 0; i < NL; i++) tag_q[i] <= tag_n[i];
    end
  end

  assign txn_active   = active;
  assign txn_depth    = depth_q;
  assign commit_pulse = commit_q;
  assign abort_pulse  = abort_q;
  assign abort_cause  = cause_q;
  assign fwd_fail     = dg_hit;
  assign line_valid   = valid_q;
  assign rd_set       = rd_q;
  assign wr_set       = wr_q;
endmodule

// File: rtl/txn_line_tracker_chk.sv
module txn_line_tracker_chk #(
  parameter int IDX_W   = 3,
  parameter int DEPTH_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  txn_active,
  input logic [DEPTH_W-1:0]    txn_depth,
  input logic                  commit_pulse,
  input logic                  abort_pulse,
  input logic [2:0]            abort_cause,
  input logic                  fwd_fail,
  input logic [(1<<IDX_W)-1:0] line_valid,
  input logic [(1<<IDX_W)-1:0] rd_set,
  input logic [(1<<IDX_W)-1:0] wr_set
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pulse && abort_pulse));

  a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (txn_depth == '0 && rd_set == '0 && wr_set == '0));

  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (txn_depth == '0 && rd_set == '0 && wr_set == '0 && abort_cause != 3'd0));

  a_r6_abort_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> ((line_valid & $past(wr_set)) == '0));

  a_r2_sets_need_txn: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_active |-> (rd_set == '0 && wr_set == '0));

  a_r9_fwd_fail_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_fail |=> abort_pulse);

  a_r4_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> (txn_depth == $past(txn_depth) ||
                      txn_depth == $past(txn_depth) + 1'b1 ||
                      txn_depth == $past(txn_depth) - 1'b1));
endmodule

bind txn_line_tracker txn_line_tracker_chk #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_chk (.*);

// File: tb/tb_txn_line_tracker.sv
`timescale 1ns/1ps
module tb_txn_line_tracker;
  localparam int IDX_W = 3, TAG_W = 4, DEPTH_W = 3, NL = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_begin, cmd_end, cmd_abort, ld_valid, st_valid, snp_rd, snp_wr;
  logic evict_valid, dgrade_valid;
  logic [IDX_W-1:0] acc_idx, snp_idx, evict_idx, dgrade_idx;
  logic [TAG_W-1:0] acc_tag;
  logic txn_active, commit_pulse, abort_pulse, fwd_fail;
  logic [DEPTH_W-1:0] txn_depth;
  logic [2:0] abort_cause;
  logic [NL-1:0] line_valid, rd_set, wr_set;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txn_line_tracker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DEPTH_W(DEPTH_W)) dut (.*);

  // {begin,end,abort}, depth, commit, abort, cause
  localparam logic [10:0] VEC [10] = '{
    {3'b100, 3'd1, 1'b0, 1'b0, 3'd0},
    {3'b100, 3'd2, 1'b0, 1'b0, 3'd0},
    {3'b010, 3'd1, 1'b0, 1'b0, 3'd0},
    {3'b100, 3'd2, 1'b0, 1'b0, 3'd0},
    {3'b010, 3'd1, 1'b0, 1'b0, 3'd0},
    {3'b010, 3'd0, 1'b1, 1'b0, 3'd0},
    {3'b010, 3'd0, 1'b0, 1'b0, 3'd0},
    {3'b100, 3'd1, 1'b0, 1'b0, 3'd0},
    {3'b001, 3'd0, 1'b0, 1'b1, 3'd1},
    {3'b001, 3'd0, 1'b0, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    {cmd_begin, cmd_end, cmd_abort, ld_valid, st_valid, snp_rd, snp_wr, evict_valid, dgrade_valid} = '0;
    acc_idx = '0; acc_tag = '0; snp_idx = '0; evict_idx = '0; dgrade_idx = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    clr();
  endtask

  task automatic beg();  cmd_begin = 1; cyc(); endtask
  task automatic fin();  cmd_end = 1;   cyc(); endtask
  task automatic abt();  cmd_abort = 1; cyc(); endtask
  task automatic ld(input int i, input int t); ld_valid = 1; acc_idx = i[IDX_W-1:0]; acc_tag = t[TAG_W-1:0]; cyc(); endtask
  task automatic st(input int i, input int t); st_valid = 1; acc_idx = i[IDX_W-1:0]; acc_tag = t[TAG_W-1:0]; cyc(); endtask

  task automatic chk_abort(input string req, input int cause);
    chk(abort_pulse === 1'b1 && commit_pulse === 1'b0, req, {commit_pulse, abort_pulse}, 2'b01);
    chk(abort_cause === cause[2:0], req, abort_cause, cause);
    chk(txn_depth === '0, req, txn_depth, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk(txn_depth === '0 && txn_active === 1'b0, "R1 depth", txn_depth, 0);
    chk(commit_pulse === 0 && abort_pulse === 0 && abort_cause === 0, "R1 pulses",
        {commit_pulse, abort_pulse, abort_cause}, 0);
    chk(line_valid === '0 && rd_set === '0 && wr_set === '0, "R1 lines",
        {line_valid, rd_set, wr_set}, 0);

    // R4 R5 R7 R12 command sequence
    for (int i = 0; i < 10; i++) begin
      {cmd_begin, cmd_end, cmd_abort} = VEC[i][10:8];
      cyc();
      chk(txn_depth === VEC[i][7:5], "R4 depth vector", txn_depth, VEC[i][7:5]);
      chk(commit_pulse === VEC[i][4], "R5 commit vector", commit_pulse, VEC[i][4]);
      chk(abort_pulse === VEC[i][3] && abort_cause === VEC[i][2:0], "R7 abort vector",
          {abort_pulse, abort_cause}, {VEC[i][3], VEC[i][2:0]});
    end

    // R2 membership marking
    ld(1, 3);
    chk(line_valid[1] === 1 && rd_set === '0, "R2 fill outside txn", {line_valid, rd_set}, 16'h0200);
    beg();
    ld(2, 0);
    chk(rd_set === 8'h04, "R2 load marks read set", rd_set, 8'h04);
    st(3, 0);
    chk(wr_set === 8'h08 && line_valid[3] === 1, "R2 store marks write set", wr_set, 8'h08);
    fin();
    chk(commit_pulse === 1 && rd_set === 0 && wr_set === 0, "R5 commit clears", {commit_pulse, rd_set, wr_set}, 17'h10000);
    chk(line_valid === 8'h0E, "R5 valid kept", line_valid, 8'h0E);
    cyc();
    chk(commit_pulse === 0, "R5 single pulse", commit_pulse, 0);

    // R3 conflicts
    beg(); ld(2, 0);
    snp_wr = 1; snp_idx = 2; cyc();
    chk_abort("R3 remote write on read set", 2);
    beg(); st(4, 0);
    snp_rd = 1; snp_idx = 4; cyc();
    chk_abort("R3 remote read on write set", 2);
    chk(line_valid[4] === 0, "R6 written line invalidated", line_valid[4], 0);

    // R12 inactive snoop and downgrade
    snp_rd = 1; snp_idx = 3; cyc();
    chk(abort_pulse === 0 && line_valid[3] === 1, "R12 snoop while inactive", {abort_pulse, line_valid[3]}, 2'b01);
    dgrade_valid = 1; dgrade_idx = 3; #0;
    chk(fwd_fail === 0, "R12 downgrade while inactive", fwd_fail, 0);
    cyc();
    chk(abort_pulse === 0 && txn_depth === 0, "R12 no state change", abort_pulse, 0);

    // R6 R7 explicit abort invalidates written only
    beg(); st(5, 0); ld(6, 0);
    abt();
    chk_abort("R7 explicit", 1);
    chk(line_valid[5] === 0 && line_valid[6] === 1, "R6 write vs read lines", line_valid[6:5], 2'b10);

    // R8 eviction
    beg(); ld(6, 0);
    evict_valid = 1; evict_idx = 6; cyc();
    chk_abort("R8 eviction", 3);
    chk(line_valid[6] === 0, "R8 evicted line invalid", line_valid[6], 0);

    // R9 downgrade
    beg(); st(1, 0);
    dgrade_valid = 1; dgrade_idx = 1; #0.5;
    chk(fwd_fail === 1, "R9 fwd_fail same cycle", fwd_fail, 1);
    cyc();
    chk_abort("R9 downgrade", 4);
    beg(); ld(2, 0);
    dgrade_valid = 1; dgrade_idx = 2; #0.5;
    chk(fwd_fail === 0, "R9 read-only downgrade flag", fwd_fail, 0);
    cyc();
    chk(abort_pulse === 0 && txn_depth === 1, "R9 read-only downgrade ignored", {abort_pulse, txn_depth}, 1);
    fin();
    chk(commit_pulse === 1, "R9 commit after ignored downgrade", commit_pulse, 1);

    // R10 capacity
    beg(); ld(2, 0); ld(2, 5);
    chk_abort("R10 tag conflict", 5);
    for (int i = 0; i < 7; i++) beg();
    chk(txn_depth === 3'd7, "R10 max depth", txn_depth, 7);
    beg();
    chk_abort("R10 depth overflow", 5);

    // R11 priorities
    beg(); st(3, 0);
    cmd_end = 1; snp_rd = 1; snp_idx = 3; cyc();
    chk_abort("R11 abort beats final end", 2);
    beg(); ld(2, 0);
    cmd_abort = 1; snp_wr = 1; snp_idx = 2; cyc();
    chk_abort("R11 explicit beats conflict", 1);
    beg(); st(1, 0);
    evict_valid = 1; evict_idx = 1; dgrade_valid = 1; dgrade_idx = 1; cyc();
    chk_abort("R11 eviction beats downgrade", 3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule